// File: doc/BRIEF.md
# Receive Volume and Sidetone Mixer

This block is the digital gain stage at the earphone end of a voice codec's receive path. Each accepted sample pair holds one signed transmit sample (microphone side) and one signed receive sample (line side). The transmit sample is scaled down by a programmable sidetone gain and added to the receive sample, so the talker hears a quiet copy of their own voice. The sum is clipped to the signed 16-bit range. It is then scaled by a receive volume attenuator that moves in fixed 2 dB steps.

The gain settings, enables and mutes come from host-written register fields, which drive this block's inputs directly. They are captured together with each sample, so a setting change affects only samples accepted after it. The receive programmable-gain setting for the later filter stage is not applied here. It is clamped to its legal range and delayed to line up with the output sample. Results leave through a registered port two clocks after the input strobe.

Top module: `rx_sidetone_mixer`

## Requirements
- R1: A sample accepted with `in_valid` high at a rising edge appears on `out_sample`, with `out_valid` high for one cycle, exactly two rising edges later. `out_valid` is low in every cycle that has no matching accepted input.
- R2: While `rst_n` is low, `out_valid`, `out_sample` and `pga_out` are all zero.
- R3: When `st_enable` is low, the transmit sample has no effect on the output.
- R4: When `mic_mute` is high, the transmit sample has no effect on the output, whatever `st_enable` is.
- R5: When `ear_mute` is high, the output sample is zero. `out_valid` still pulses as in R1.
- R6: Sidetone code c (3 bits) selects -(12+2c) dB for c = 0..6, and code 7 clamps to -24 dB. Code 0 (-12 dB) is the cleared-register default. Gains in Q2.14 are 4115, 3269, 2597, 2063, 1638, 1301, 1034.
- R7: Volume code c (4 bits) selects -2c dB for c = 0..9, and codes 10..15 clamp to -18 dB. Code 0 (0 dB, unity) is the cleared-register default. Gains in Q2.14 are 16384, 13014, 10338, 8211, 6523, 5181, 4115, 3269, 2597, 2063.
- R8: Each gain is applied as y = floor(x * G / 16384), with G taken from the R6 and R7 tables. The sidetone term is added to the receive sample, and volume is applied to the clipped sum.
- R9: The receive-plus-sidetone sum saturates to [-32768, 32767] instead of wrapping.
- R10: `pga_out` carries `pga_code` with the R1 latency, where code c means (c-6) dB. Codes above 12 clamp to 12.
- R11: All gain codes, enables and mutes are sampled together with the sample they apply to. Back-to-back samples with different settings each use their own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| tx_sample | input | 16 | Signed transmit sample |
| rx_sample | input | 16 | Signed receive sample |
| st_enable | input | 1 | Sidetone path enable |
| mic_mute | input | 1 | Forces the transmit contribution to zero |
| ear_mute | input | 1 | Forces the output sample to zero |
| st_gain_code | input | 3 | Sidetone attenuation step |
| vol_code | input | 4 | Receive volume step |
| pga_code | input | 4 | Receive programmable-gain setting to pass on |
| out_valid | output | 1 | Output strobe |
| out_sample | output | 16 | Signed mixed and attenuated sample |
| pga_out | output | 4 | Clamped receive gain setting aligned with `out_sample` |

## Verification
A wrong gain entry or a bad clamp shows up as an output sample that differs from the floor-rounded reference. This appears two cycles after the first sample that uses that step. For that reason every code, including the clamped ones, is driven directly. A wrapping adder, or a lost mute or enable, corrupts the first sample at full-scale or muted input. Saturation cases are therefore driven with extreme values in both signs. A pipeline mistake that mixes settings with the wrong sample only shows up under back-to-back strobes whose settings change every cycle. The random stream drives exactly that, and it also checks that `out_valid` stays low in idle cycles.

// File: rtl/rx_sidetone_mixer.sv
module rx_sidetone_mixer #(
  parameter int DW      = 16,
  parameter int GW      = 16,
  parameter int FRAC    = 14,
  parameter int SCW     = 3,
  parameter int VCW     = 4,
  parameter int PCW     = 4,
  parameter int PGA_MAX = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [DW-1:0]  tx_sample,
  input  logic [DW-1:0]  rx_sample,
  input  logic           st_enable,
  input  logic           mic_mute,
  input  logic           ear_mute,
  input  logic [SCW-1:0] st_gain_code,
  input  logic [VCW-1:0] vol_code,
  input  logic [PCW-1:0] pga_code,
  output logic           out_valid,
  output logic [DW-1:0]  out_sample,
  output logic [PCW-1:0] pga_out
);

  localparam int PW = DW + GW + 1;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] SAT_HI = SW'((2 ** (DW - 1)) - 1);
  localparam logic signed [SW-1:0] SAT_LO = -SW'(2 ** (DW - 1));

  function automatic logic [GW-1:0] st_gain(input logic [SCW-1:0] c);
    case (c)
      3'd0:    st_gain = GW'(4115);
      3'd1:    st_gain = GW'(3269);
      3'd2:    st_gain = GW'(2597);
      3'd3:    st_gain = GW'(2063);
      3'd4:    st_gain = GW'(1638);
      3'd5:    st_gain = GW'(1301);
      default: st_gain = GW'(1034);
    endcase
  endfunction

  function automatic logic [GW-1:0] vol_gain(input logic [VCW-1:0] c);
    case (c)
      4'd0:    vol_gain = GW'(16384);
      4'd1:    vol_gain = GW'(13014);
      4'd2:    vol_gain = GW'(10338);
      4'd3:    vol_gain = GW'(8211);
      4'd4:    vol_gain = GW'(6523);
      4'd5:    vol_gain = GW'(5181);
      4'd6:    vol_gain = GW'(4115);
      4'd7:    vol_gain = GW'(3269);
      4'd8:    vol_gain = GW'(2597);
      default: vol_gain = GW'(2063);
    endcase
  endfunction

  logic signed [DW-1:0] tx_s, rx_s, tx_eff;
  logic signed [PW-1:0] st_prod, st_term;
  logic signed [SW-1:0] sum_w;
  logic signed [DW-1:0] sum_sat;

  assign tx_s    = tx_sample;
  assign rx_s    = rx_sample;
  assign tx_eff  = (st_enable && !mic_mute) ? tx_s : '0;
  assign st_prod = tx_eff * $signed({1'b0, st_gain(st_gain_code)});
  assign st_term = st_prod >>> FRAC;
  assign sum_w   = SW'(st_term) + SW'(rx_s);
  assign sum_sat = (sum_w > SAT_HI) ? DW'(SAT_HI) :
                   (sum_w < SAT_LO) ? DW'(SAT_LO) : sum_w[DW-1:0];

  logic                 s1_vld, s1_mute;
  logic signed [DW-1:0] s1_sum;
  logic [GW-1:0]        s1_vgain;
  logic [PCW-1:0]       s1_pga;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_mute  <= 1'b0;
      s1_sum   <= '0;
      s1_vgain <= '0;
      s1_pga   <= '0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_mute  <= ear_mute;
        s1_sum   <= sum_sat;
        s1_vgain <= vol_gain(vol_code);
        s1_pga   <= (pga_code > PCW'(PGA_MAX)) ? PCW'(PGA_MAX) : pga_code;
      end
    end
  end

  logic signed [PW-1:0] v_prod, v_term;
  assign v_prod = s1_sum * $signed({1'b0, s1_vgain});
  assign v_term = v_prod >>> FRAC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      pga_out    <= '0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_sample <= s1_mute ? '0 : v_term[DW-1:0];
        pga_out    <= s1_pga;
      end
    end
  end

  function automatic int unsigned mag(input logic signed [DW-1:0] v);
    mag = (v < 0) ? int'(-int'(v)) : int'(v);
  endfunction

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid); // R1
  AST_ST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !st_enable && !ear_mute && vol_code == '0)
      |=> ##1 (out_sample == $past(rx_sample, 2))); // R3
  AST_MIC_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mic_mute && !ear_mute && vol_code == '0)
      |=> ##1 (out_sample == $past(rx_sample, 2))); // R4
  AST_EAR_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ear_mute) |=> ##1 (out_sample == '0)); // R5
  AST_VOL_ATTEN: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> (mag(out_sample) <= mag($past(s1_sum)))); // R7
  AST_PGA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pga_out <= PCW'(PGA_MAX))); // R10

endmodule

// File: tb/rx_sidetone_mixer_tb.sv
module rx_sidetone_mixer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [15:0] tx_sample = '0, rx_sample = '0;
  logic st_enable = 1'b0, mic_mute = 1'b0, ear_mute = 1'b0;
  logic [2:0] st_gain_code = '0;
  logic [3:0] vol_code = '0, pga_code = '0;
  logic out_valid;
  logic [15:0] out_sample;
  logic [3:0] pga_out;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_sidetone_mixer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .tx_sample(tx_sample), .rx_sample(rx_sample),
    .st_enable(st_enable), .mic_mute(mic_mute), .ear_mute(ear_mute),
    .st_gain_code(st_gain_code), .vol_code(vol_code), .pga_code(pga_code),
    .out_valid(out_valid), .out_sample(out_sample), .pga_out(pga_out)
  );

  function automatic longint stg(input int c);
    case (c)
      0: return 4115; 1: return 3269; 2: return 2597; 3: return 2063;
      4: return 1638; 5: return 1301; default: return 1034;
    endcase
  endfunction

  function automatic longint vg(input int c);
    case (c)
      0: return 16384; 1: return 13014; 2: return 10338; 3: return 8211;
      4: return 6523;  5: return 5181;  6: return 4115;  7: return 3269;
      8: return 2597;  default: return 2063;
    endcase
  endfunction

  function automatic logic [15:0] model(input logic [15:0] tx, input logic [15:0] rx,
      input logic en, input logic mm, input logic em, input int sc, input int vc);
    longint st, s, o;
    st = (en && !mm) ? ((longint'($signed(tx)) * stg(sc)) >>> 14) : 0;
    s = longint'($signed(rx)) + st;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    o = em ? 0 : ((s * vg(vc)) >>> 14);
    return o[15:0];
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic        h_v[2];
  logic [15:0] h_d[2];
  logic [3:0]  h_p[2];
  string       h_t[2];

  task automatic step(input logic v, input logic [15:0] tx, input logic [15:0] rx,
      input logic en, input logic mm, input logic em, input int sc, input int vc,
      input int pc, input string tag);
    if (h_v[1]) begin
      chk("R1 valid", out_valid, 1);
      chk(h_t[1], $signed(out_sample), $signed(h_d[1]));
      chk("R10 pga", pga_out, h_p[1]);
    end else begin
      chk("R1 idle", out_valid, 0);
    end
    h_v[1] = h_v[0]; h_d[1] = h_d[0]; h_p[1] = h_p[0]; h_t[1] = h_t[0];
    in_valid = v; tx_sample = tx; rx_sample = rx; st_enable = en;
    mic_mute = mm; ear_mute = em; st_gain_code = 3'(sc); vol_code = 4'(vc);
    pga_code = 4'(pc);
    h_v[0] = v;
    h_d[0] = model(tx, rx, en, mm, em, sc, vc);
    h_p[0] = (pc > 12) ? 4'd12 : 4'(pc);
    h_t[0] = tag;
    @(negedge clk);
  endtask

  task automatic idle2();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    h_v[0] = 0; h_v[1] = 0; h_t[0] = "R1"; h_t[1] = "R1";
    h_d[0] = '0; h_d[1] = '0; h_p[0] = '0; h_p[1] = '0;
    repeat (3) @(negedge clk);
    chk("R2 out_valid", out_valid, 0);
    chk("R2 out_sample", out_sample, 0);
    chk("R2 pga_out", pga_out, 0);
    rst_n = 1'b1;

    step(1, 16'h4000, 16'd1000, 0, 0, 0, 0, 0, 6, "R3 sidetone off");
    step(1, 16'h7fff, 16'hfc18, 1, 1, 0, 3, 0, 6, "R4 mic mute");
    step(1, 16'h1234, 16'h2345, 1, 0, 1, 0, 0, 6, "R5 ear mute");
    step(1, 16'h7fff, 16'h7fff, 1, 0, 0, 0, 0, 15, "R9 positive clip");
    step(1, 16'h8000, 16'h8000, 1, 0, 0, 0, 0, 13, "R9 negative clip");
    step(1, 16'h8000, 16'h8000, 1, 0, 0, 0, 9, 12, "R9 R7 clip then -18dB");
    idle2();
    for (int c = 0; c < 8; c++)
      step(1, 16'h6000, 16'h0000, 1, 0, 0, c, 0, c, "R6 sidetone step");
    for (int c = 0; c < 16; c++)
      step(1, 16'h0000, 16'h9abc, 0, 0, 0, 0, c, c, "R7 volume step");
    step(1, 16'hffff, 16'h0000, 1, 0, 0, 6, 0, 0, "R8 floor rounding");
    step(1, 16'h0003, 16'hffff, 0, 0, 0, 0, 1, 0, "R8 floor negative");
    idle2();
    for (int i = 0; i < 400; i++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(v, 16'($urandom), 16'($urandom), 1'($urandom), 1'(($urandom % 5) == 0),
           1'(($urandom % 7) == 0), int'($urandom % 8), int'($urandom % 16),
           int'($urandom % 16), "R8 R11 random stream");
    end
    idle2();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule